// File: doc/BRIEF.md
# Single-Wire Slave Command Sequencer

This block is the byte-level controller of a slave on a single-wire serial memory bus. A separate bit engine recovers bytes and acknowledge bits from the wire. The bit engine signals a completed start header, each received byte, each master acknowledge bit (continue or stop), a standby pulse and loss of synchronisation. The sequencer checks the device address and decodes the command byte. It gathers a two-byte word address and then steps through the data phase one byte at a time, following the master's acknowledges.

For every byte it decides whether the slave acknowledges. It tells the bit engine which byte to send back, and it holds the current-address counter that drives the memory read port. Operations that change stored state go to a separate write-control unit as one-cycle operation codes. The sequencer has three modes. In standby it waits for a header. In active it works through a command. In idle it ignores the wire until a standby pulse arrives.

All inputs are single-cycle pulses, at most one event per cycle. All outputs are registered. An event presented on a clock edge shows its result in the cycle after that edge. A slave byte that comes from the memory array follows one cycle later again.

Top module: `sw_cmd_seq`

## Requirements
- R1: The first byte after a header must equal DEV_ID (0xA0 by default). Any other value gets a non-acknowledge at the next acknowledge slot, and the block moves to idle. A matching byte gets an acknowledge.
- R2: The command byte is decoded as follows: 0x03 random read, 0x06 current-address read, 0x6C write, 0x96 write-enable, 0x91 write-disable, 0x05 status read, 0x6E status write, 0x6D fill with 0x00, 0x67 fill with 0xFF. Any other code gets a non-acknowledge and leads to idle.
- R3: While wr_busy is high, the following commands get a non-acknowledge and lead to idle: random read, current-address read, write, status write and both fills. Status read and write-enable are still accepted.
- R4: A random read takes a high and then a low address byte, each acknowledged. tx_byte then carries the memory byte at that address. Each continue moves to the next address, and the address wraps from the top of the array to 0x00.
- R5: The counter loads at the master acknowledge of each address byte. It increments at the master acknowledge (continue or stop) after each data byte. It is unchanged when a standby pulse arrives in place of that acknowledge. A current-address read starts at the counter.
- R6: Each write data byte is issued as wc_op=3 at the counter address. The counter then steps only within its 2^PAGE_W-byte page. A stop after data gets an acknowledge and wc_op=4. A stop after the low address byte, before any data, gets a non-acknowledge and leads to idle with no operation.
- R7: The commands write-enable (wc_op=1), write-disable (wc_op=2), fill 0x00 (wc_op=6, wc_data 0x00) and fill 0xFF (wc_op=7, wc_data 0xFF) must be followed by a stop. That stop gets an acknowledge and issues the operation. A continue there gets a non-acknowledge, leads to idle and issues nothing.
- R8: A status read sends {4'b0, bp_i[1:0], wel_i, wr_busy}. Each continue sends it again, sampled afresh, until a stop.
- R9: A status write takes one data byte. A stop then gets an acknowledge and wc_op=5 with that byte. A continue gets a non-acknowledge and leads to idle.
- R10: A stop directly after the device address gets an acknowledge. A stop after the command byte of a read, write, status read or status write command gets a non-acknowledge and leads to idle. A stop after either address byte gets the same treatment.
- R11: A command ended by a stop that receives an acknowledge returns the block to standby (mode 0). A new header is then accepted without a standby pulse.
- R12: In idle (mode 2) every input except stby_pulse is ignored. sync_err forces idle from any state. stby_pulse forces standby from any state and takes precedence.
- R13: After reset the block is in standby with no acknowledge, transmit or write-control pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_ok | input | 1 | Start header completed |
| byte_vld | input | 1 | A byte from the master is complete |
| byte_in | input | 8 | Received byte |
| mak_vld | input | 1 | Master acknowledge bit received |
| mak_cont | input | 1 | 1 = continue, 0 = stop |
| stby_pulse | input | 1 | Standby pulse detected |
| sync_err | input | 1 | Bit engine lost synchronisation |
| wr_busy | input | 1 | Write cycle in progress |
| wel_i | input | 1 | Write-enable latch state |
| bp_i | input | 2 | Block-protect setting |
| rd_data | input | 8 | Memory byte at rd_addr |
| rd_addr | output | ADDR_W | Current-address counter |
| ack_vld | output | 1 | Slave acknowledge decision valid |
| ack_sak | output | 1 | 1 = acknowledge, 0 = non-acknowledge |
| tx_load | output | 1 | Byte to transmit is valid |
| tx_byte | output | 8 | Byte to transmit |
| wc_op | output | 3 | Write-control operation, 0 = none |
| wc_addr | output | ADDR_W | Address for a data load |
| wc_data | output | 8 | Data for a load, status write or fill |
| mode | output | 2 | 0 standby, 1 active, 2 idle |

## Verification
Sequential reads start near the top of the array, which shows whether the counter wraps to zero after the top address. Writes start two bytes below a page boundary, which separates a page-local wrap from a full increment. A read is broken off by a standby pulse and followed by a current-address read; this shows whether the counter moves only on acknowledges. Each command class is tried with both continue and stop in its final acknowledge slot, and with wr_busy high. These runs separate the legal endings from the ones that must give a non-acknowledge and idle. They also check that idle swallows a full header, address and acknowledge.

// File: rtl/sw_cmd_seq_pkg.sv
package sw_cmd_seq_pkg;

    localparam logic [7:0] CODE_READ  = 8'h03;
    localparam logic [7:0] CODE_CURRD = 8'h06;
    localparam logic [7:0] CODE_WRITE = 8'h6C;
    localparam logic [7:0] CODE_WEN   = 8'h96;
    localparam logic [7:0] CODE_WDIS  = 8'h91;
    localparam logic [7:0] CODE_RDST  = 8'h05;
    localparam logic [7:0] CODE_WRST  = 8'h6E;
    localparam logic [7:0] CODE_FILL0 = 8'h6D;
    localparam logic [7:0] CODE_FILL1 = 8'h67;

    typedef enum logic [3:0] {
        C_BAD, C_READ, C_CURRD, C_WRITE, C_WEN, C_WDIS,
        C_RDST, C_WRST, C_FILL0, C_FILL1
    } cmd_e;

    typedef enum logic [2:0] {
        WC_NONE = 3'd0, WC_WEL_SET = 3'd1, WC_WEL_CLR = 3'd2, WC_LOAD = 3'd3,
        WC_COMMIT = 3'd4, WC_SRW = 3'd5, WC_FILL0 = 3'd6, WC_FILL1 = 3'd7
    } wc_op_e;

    typedef enum logic [1:0] {
        MD_STBY = 2'd0, MD_ACTIVE = 2'd1, MD_IDLE = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        CT_HOLD, CT_LD_HI, CT_LD_LO, CT_INC, CT_INC_PAGE
    } ctr_op_e;

    typedef enum logic [4:0] {
        S_STBY, S_DEV, S_DEV_ACK, S_REJ, S_CMD, S_CMD_ACK,
        S_AHI, S_AHI_ACK, S_ALO, S_ALO_ACK, S_FETCH, S_RDATA,
        S_WDATA, S_WDATA_ACK, S_SRD, S_SRW, S_SRW_ACK, S_IDLE
    } state_e;

    function automatic mode_e mode_of(state_e s);
        case (s)
            S_STBY:  return MD_STBY;
            S_IDLE:  return MD_IDLE;
            default: return MD_ACTIVE;
        endcase
    endfunction

    function automatic logic needs_quiet_array(cmd_e c);
        return (c == C_READ) || (c == C_CURRD) || (c == C_WRITE) ||
               (c == C_WRST) || (c == C_FILL0) || (c == C_FILL1);
    endfunction

endpackage

// File: rtl/sw_cmd_seq_decode.sv
module sw_cmd_seq_decode
    import sw_cmd_seq_pkg::*;
(
    input  logic [7:0] code,
    output cmd_e       cls,
    output logic       busy_block
);
    always_comb begin
        case (code)
            CODE_READ:  cls = C_READ;
            CODE_CURRD: cls = C_CURRD;
            CODE_WRITE: cls = C_WRITE;
            CODE_WEN:   cls = C_WEN;
            CODE_WDIS:  cls = C_WDIS;
            CODE_RDST:  cls = C_RDST;
            CODE_WRST:  cls = C_WRST;
            CODE_FILL0: cls = C_FILL0;
            CODE_FILL1: cls = C_FILL1;
            default:    cls = C_BAD;
        endcase
        busy_block = needs_quiet_array(cls);
    end
endmodule

// File: rtl/sw_cmd_seq_ctr.sv
module sw_cmd_seq_ctr
    import sw_cmd_seq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  ctr_op_e           op,
    input  logic [7:0]        hi,
    input  logic [7:0]        lo,
    output logic [ADDR_W-1:0] ctr
);
    logic [ADDR_W-1:0] ctr_q;
    logic [ADDR_W-1:0] page_next;
    logic [7:0]        low8;

    assign low8 = 8'(ctr_q);

    generate
        if (PAGE_W < ADDR_W) begin : g_paged
            assign page_next = {ctr_q[ADDR_W-1:PAGE_W], ctr_q[PAGE_W-1:0] + 1'b1};
        end else begin : g_flat
            assign page_next = ctr_q + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_q <= '0;
        end else begin
            case (op)
                CT_LD_HI:    ctr_q <= ADDR_W'({hi, low8});
                CT_LD_LO:    ctr_q <= ADDR_W'({hi, lo});
                CT_INC:      ctr_q <= ctr_q + 1'b1;
                CT_INC_PAGE: ctr_q <= page_next;
                default:     ctr_q <= ctr_q;
            endcase
        end
    end

    assign ctr = ctr_q;
endmodule

// File: rtl/sw_cmd_seq.sv
module sw_cmd_seq
    import sw_cmd_seq_pkg::*;
#(
    parameter int         ADDR_W = 8,
    parameter int         PAGE_W = 4,
    parameter logic [7:0] DEV_ID = 8'hA0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hdr_ok,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    input  logic              mak_vld,
    input  logic              mak_cont,
    input  logic              stby_pulse,
    input  logic              sync_err,
    input  logic              wr_busy,
    input  logic              wel_i,
    input  logic [1:0]        bp_i,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              ack_vld,
    output logic              ack_sak,
    output logic              tx_load,
    output logic [7:0]        tx_byte,
    output logic [2:0]        wc_op,
    output logic [ADDR_W-1:0] wc_addr,
    output logic [7:0]        wc_data,
    output logic [1:0]        mode
);
    state_e            st, st_n;
    cmd_e              cmd_q, cmd_n, dec_cls;
    logic              dec_blk;
    logic [7:0]        ahi_q, ahi_n, dat_q, dat_n;
    logic              ack_v_n, ack_s_n, txl_n;
    logic [7:0]        txb_n, wd_n;
    wc_op_e            op_n, op_q;
    logic [ADDR_W-1:0] wa_n, ctr;
    ctr_op_e           ctr_op;
    logic [7:0]        status_byte;

    assign status_byte = {4'b0000, bp_i, wel_i, wr_busy};

    sw_cmd_seq_decode u_dec (.code(byte_in), .cls(dec_cls), .busy_block(dec_blk));

    sw_cmd_seq_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
        .clk(clk), .rst(rst), .op(ctr_op), .hi(ahi_q), .lo(dat_q), .ctr(ctr)
    );

    always_comb begin
        st_n = st;   cmd_n = cmd_q; ahi_n = ahi_q; dat_n = dat_q;
        ack_v_n = 1'b0; ack_s_n = 1'b0; txl_n = 1'b0; txb_n = tx_byte;
        op_n = WC_NONE; wa_n = wc_addr; wd_n = wc_data; ctr_op = CT_HOLD;
        if (stby_pulse) begin
            st_n = S_STBY;
        end else if (sync_err) begin
            st_n = S_IDLE;
        end else begin
            case (st)
                S_STBY: if (hdr_ok) st_n = S_DEV;
                S_DEV: if (byte_vld) st_n = (byte_in == DEV_ID) ? S_DEV_ACK : S_REJ;
                S_REJ: if (mak_vld) begin ack_v_n = 1'b1; st_n = S_IDLE; end
                S_DEV_ACK: if (mak_vld) begin
                    ack_v_n = 1'b1; ack_s_n = 1'b1;
                    st_n = mak_cont ? S_CMD : S_STBY;
                end
                S_CMD: if (byte_vld) begin
                    cmd_n = dec_cls;
                    st_n  = (dec_cls == C_BAD || (dec_blk && wr_busy)) ? S_REJ : S_CMD_ACK;
                end
                S_CMD_ACK: if (mak_vld) begin
                    ack_v_n = 1'b1;
                    st_n    = S_IDLE;
                    case (cmd_q)
                        C_WEN, C_WDIS, C_FILL0, C_FILL1: if (!mak_cont) begin
                            ack_s_n = 1'b1; st_n = S_STBY;
                            case (cmd_q)
                                C_WEN:   op_n = WC_WEL_SET;
                                C_WDIS:  op_n = WC_WEL_CLR;
                                C_FILL0: begin op_n = WC_FILL0; wd_n = 8'h00; end
                                default: begin op_n = WC_FILL1; wd_n = 8'hFF; end
                            endcase
                        end
                        default: if (mak_cont) begin
                            ack_s_n = 1'b1;
                            case (cmd_q)
                                C_CURRD: st_n = S_FETCH;
                                C_RDST:  begin st_n = S_SRD; txl_n = 1'b1; txb_n = status_byte; end
                                C_WRST:  st_n = S_SRW;
                                default: st_n = S_AHI;
                            endcase
                        end
                    endcase
                end
                S_AHI: if (byte_vld) begin ahi_n = byte_in; st_n = S_AHI_ACK; end
                S_AHI_ACK: if (mak_vld) begin
                    ack_v_n = 1'b1; ctr_op = CT_LD_HI; ack_s_n = mak_cont;
                    st_n = mak_cont ? S_ALO : S_IDLE;
                end
                S_ALO: if (byte_vld) begin dat_n = byte_in; st_n = S_ALO_ACK; end
                S_ALO_ACK: if (mak_vld) begin
                    ack_v_n = 1'b1; ctr_op = CT_LD_LO; ack_s_n = mak_cont;
                    if (!mak_cont)              st_n = S_IDLE;
                    else if (cmd_q == C_WRITE)  st_n = S_WDATA;
                    else                        st_n = S_FETCH;
                end
                S_FETCH: begin txl_n = 1'b1; txb_n = rd_data; st_n = S_RDATA; end
                S_RDATA: if (mak_vld) begin
                    ack_v_n = 1'b1; ack_s_n = 1'b1; ctr_op = CT_INC;
                    st_n = mak_cont ? S_FETCH : S_STBY;
                end
                S_WDATA: if (byte_vld) begin
                    op_n = WC_LOAD; wa_n = ctr; wd_n = byte_in; st_n = S_WDATA_ACK;
                end
                S_WDATA_ACK: if (mak_vld) begin
                    ack_v_n = 1'b1; ack_s_n = 1'b1; ctr_op = CT_INC_PAGE;
                    if (mak_cont) st_n = S_WDATA;
                    else begin op_n = WC_COMMIT; st_n = S_STBY; end
                end
                S_SRD: if (mak_vld) begin
                    ack_v_n = 1'b1; ack_s_n = 1'b1;
                    if (mak_cont) begin txl_n = 1'b1; txb_n = status_byte; end
                    else st_n = S_STBY;
                end
                S_SRW: if (byte_vld) begin dat_n = byte_in; st_n = S_SRW_ACK; end
                S_SRW_ACK: if (mak_vld) begin
                    ack_v_n = 1'b1;
                    if (mak_cont) st_n = S_IDLE;
                    else begin
                        ack_s_n = 1'b1; op_n = WC_SRW; wd_n = dat_q; st_n = S_STBY;
                    end
                end
                default: st_n = st;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_STBY; cmd_q <= C_BAD; ahi_q <= '0; dat_q <= '0;
            ack_vld <= 1'b0; ack_sak <= 1'b0; tx_load <= 1'b0; tx_byte <= '0;
            op_q <= WC_NONE; wc_addr <= '0; wc_data <= '0;
        end else begin
            st <= st_n; cmd_q <= cmd_n; ahi_q <= ahi_n; dat_q <= dat_n;
            ack_vld <= ack_v_n; ack_sak <= ack_s_n; tx_load <= txl_n; tx_byte <= txb_n;
            op_q <= op_n; wc_addr <= wa_n; wc_data <= wd_n;
        end
    end

    assign wc_op   = op_q;
    assign mode    = mode_of(st);
    assign rd_addr = ctr;
endmodule

// File: rtl/sw_cmd_seq_chk.sv
module sw_cmd_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       stby_pulse,
    input logic       sync_err,
    input logic [1:0] mode,
    input logic       ack_vld,
    input logic       ack_sak,
    input logic       tx_load,
    input logic [2:0] wc_op
);
    // R12: idle produces no acknowledge, transmit or write-control pulse
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2 && !stby_pulse) |=> (!ack_vld && !tx_load && wc_op == 3'd0));

    // R12: sync error leads to idle
    a_r12_sync_idle: assert property (@(posedge clk) disable iff (rst)
        (sync_err && !stby_pulse) |=> (mode == 2'd2));

    // R12: standby pulse leads to standby
    a_r12_stby: assert property (@(posedge clk) disable iff (rst)
        stby_pulse |=> (mode == 2'd0));

    // R10: every non-acknowledge comes with idle
    a_r10_nosak_idle: assert property (@(posedge clk) disable iff (rst)
        (ack_vld && !ack_sak) |-> (mode == 2'd2));

    // R6: a commit is issued only with an acknowledge, entering standby
    a_r6_commit_sak: assert property (@(posedge clk) disable iff (rst)
        (wc_op == 3'd4) |-> (ack_vld && ack_sak && mode == 2'd0));

    // R8: bytes are only handed to the bit engine while active
    a_r8_tx_active: assert property (@(posedge clk) disable iff (rst)
        tx_load |-> (mode == 2'd1));
endmodule

bind sw_cmd_seq sw_cmd_seq_chk u_chk (
    .clk(clk), .rst(rst), .stby_pulse(stby_pulse), .sync_err(sync_err),
    .mode(mode), .ack_vld(ack_vld), .ack_sak(ack_sak), .tx_load(tx_load),
    .wc_op(wc_op)
);

// File: tb/sw_cmd_seq_test.sv
module sw_cmd_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hdr_ok = 0, byte_vld = 0, mak_vld = 0, mak_cont = 0;
    logic stby_pulse = 0, sync_err = 0, wr_busy = 0, wel_i = 0;
    logic [7:0] byte_in = 0;
    logic [1:0] bp_i = 0;
    logic [7:0] rd_data;
    logic [AW-1:0] rd_addr, wc_addr;
    logic ack_vld, ack_sak, tx_load;
    logic [7:0] tx_byte, wc_data;
    logic [2:0] wc_op;
    logic [1:0] mode;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign rd_data = rd_addr ^ 8'h5A;

    sw_cmd_seq uut (
        .clk(clk), .rst(rst), .hdr_ok(hdr_ok), .byte_vld(byte_vld), .byte_in(byte_in),
        .mak_vld(mak_vld), .mak_cont(mak_cont), .stby_pulse(stby_pulse),
        .sync_err(sync_err), .wr_busy(wr_busy), .wel_i(wel_i), .bp_i(bp_i),
        .rd_data(rd_data), .rd_addr(rd_addr), .ack_vld(ack_vld), .ack_sak(ack_sak),
        .tx_load(tx_load), .tx_byte(tx_byte), .wc_op(wc_op), .wc_addr(wc_addr),
        .wc_data(wc_data), .mode(mode)
    );

    task automatic chk(input string what, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", what, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        hdr_ok = 0; byte_vld = 0; mak_vld = 0; stby_pulse = 0; sync_err = 0;
    endtask

    task automatic hdr();            hdr_ok = 1; step(); endtask
    task automatic tx(input logic [7:0] b); byte_in = b; byte_vld = 1; step(); endtask
    task automatic mak(input logic c); mak_cont = c; mak_vld = 1; step(); endtask
    task automatic stby();           stby_pulse = 1; step(); endtask

    task automatic open_cmd(input logic [7:0] code);
        hdr(); tx(8'hA0); mak(1); tx(code);
    endtask

    task automatic t_reset();
        chk("R13 mode", mode, 0);
        chk("R13 ack", ack_vld, 0);
        chk("R13 op", wc_op, 0);
    endtask

    task automatic t_bad_dev();
        hdr(); tx(8'hA1); mak(1);
        chk("R1 bad dev ack_vld", ack_vld, 1);
        chk("R1 bad dev sak", ack_sak, 0);
        chk("R1 bad dev mode", mode, 2);
        hdr(); tx(8'hA0); mak(1);
        chk("R12 idle ignores ack", ack_vld, 0);
        chk("R12 idle stays", mode, 2);
        stby();
        chk("R12 standby pulse", mode, 0);
    endtask

    task automatic t_dev_stop();
        hdr(); tx(8'hA0); mak(0);
        chk("R10 stop after dev sak", {ack_vld, ack_sak}, 3);
        chk("R11 standby", mode, 0);
        hdr(); tx(8'hA0); mak(1);
        chk("R11 new header without pulse", {ack_vld, ack_sak}, 3);
        chk("R1 good dev active", mode, 1);
        stby();
    endtask

    task automatic t_unknown();
        open_cmd(8'h55); mak(1);
        chk("R2 unknown nosak", {ack_vld, ack_sak}, 2);
        chk("R2 unknown idle", mode, 2);
        stby();
        open_cmd(8'h03); mak(0);
        chk("R10 stop after read cmd", {ack_vld, ack_sak, mode}, 'b1010);
        stby();
    endtask

    task automatic t_read();
        open_cmd(8'h03); mak(1);
        chk("R2 read cmd sak", {ack_vld, ack_sak}, 3);
        tx(8'h00); mak(1);
        tx(8'hFE); mak(1);
        chk("R4 low addr sak", {ack_vld, ack_sak}, 3);
        step();
        chk("R4 first byte", {tx_load, tx_byte}, {1'b1, 8'hFE ^ 8'h5A});
        mak(1); step();
        chk("R4 second byte", {tx_load, tx_byte}, {1'b1, 8'hFF ^ 8'h5A});
        mak(1); step();
        chk("R4 wrap to 00", {tx_load, tx_byte}, {1'b1, 8'h5A});
        mak(0);
        chk("R11 read end sak", {ack_vld, ack_sak, mode}, 'b1100);
    endtask

    task automatic t_crrd();
        open_cmd(8'h06); mak(1); step();
        chk("R5 current read", tx_byte, 8'h01 ^ 8'h5A);
        stby();
        open_cmd(8'h06); mak(1); step();
        chk("R5 unchanged after standby", tx_byte, 8'h01 ^ 8'h5A);
        stby();
    endtask

    task automatic t_write();
        open_cmd(8'h96); mak(0);
        chk("R7 wen op", {ack_sak, wc_op}, {1'b1, 3'd1});
        open_cmd(8'h6C); mak(1); tx(8'h00); mak(1); tx(8'h1E); mak(1);
        tx(8'h11);
        chk("R6 load 1", {wc_op, wc_addr, wc_data}, {3'd3, 8'h1E, 8'h11});
        mak(1); tx(8'h22);
        chk("R6 load 2", {wc_op, wc_addr}, {3'd3, 8'h1F});
        mak(1); tx(8'h33);
        chk("R6 page wrap", {wc_op, wc_addr}, {3'd3, 8'h10});
        mak(0);
        chk("R6 commit", {ack_vld, ack_sak, wc_op, mode}, {2'b11, 3'd4, 2'd0});
        open_cmd(8'h6C); mak(1); tx(8'h00); mak(1); tx(8'h20); mak(0);
        chk("R6 no data nosak", {ack_vld, ack_sak, wc_op, mode}, {2'b10, 3'd0, 2'd2});
        stby();
    endtask

    task automatic t_cmd_end();
        open_cmd(8'h91); mak(1);
        chk("R7 wdis continue", {ack_sak, wc_op, mode}, {1'b0, 3'd0, 2'd2});
        stby();
        open_cmd(8'h91); mak(0);
        chk("R7 wdis op", {ack_sak, wc_op}, {1'b1, 3'd2});
        open_cmd(8'h67); mak(0);
        chk("R7 fill ff", {wc_op, wc_data}, {3'd7, 8'hFF});
        open_cmd(8'h6D); mak(0);
        chk("R7 fill 00", {wc_op, wc_data}, {3'd6, 8'h00});
    endtask

    task automatic t_busy();
        wr_busy = 1; bp_i = 2'b10; wel_i = 1;
        open_cmd(8'h03); mak(1);
        chk("R3 read blocked", {ack_vld, ack_sak, mode}, 'b1010);
        stby();
        open_cmd(8'h05); mak(1);
        chk("R3 status allowed", {ack_sak, tx_load, tx_byte}, {2'b11, 8'h0B});
        wel_i = 0; mak(1);
        chk("R8 status again", {ack_sak, tx_load, tx_byte}, {2'b11, 8'h09});
        mak(0);
        chk("R8 status end", {ack_sak, tx_load, mode}, {2'b10, 2'd0});
        open_cmd(8'h96); mak(0);
        chk("R3 wen allowed busy", wc_op, 1);
        wr_busy = 0; bp_i = 0;
    endtask

    task automatic t_wrsr();
        open_cmd(8'h6E); mak(1); tx(8'h0C); mak(0);
        chk("R9 status write", {ack_sak, wc_op, wc_data}, {1'b1, 3'd5, 8'h0C});
        open_cmd(8'h6E); mak(1); tx(8'h04); mak(1);
        chk("R9 continue rejected", {ack_vld, ack_sak, wc_op, mode}, {2'b10, 3'd0, 2'd2});
        stby();
    endtask

    task automatic t_sync();
        hdr(); tx(8'hA0);
        sync_err = 1; step();
        chk("R12 sync error idle", mode, 2);
        stby();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset(); t_bad_dev(); t_dev_stop(); t_unknown(); t_read(); t_crrd();
        t_write(); t_cmd_end(); t_busy(); t_wrsr(); t_sync();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule